// File: doc/BRIEF.md
# Synchronous Burst Data Launcher

This block drives write data onto a 16-bit multiplexed address/data bus in synchronous mode, and it also produces the bus clock. The far device captures data only on rising edges of that clock. The block runs on a timing clock at twice the functional clock rate. This lets it place both bus clock edges, and every data change, on registered timing ticks. A 2-bit divider setting selects the bus clock frequency: the functional clock divided by one, two, three or four.

A request carries a word count and a burst-enable bit, and it is accepted when the block is idle. Words then come in over a ready/valid stream. Each word is taken exactly one tick before the edge that launches it. The launch edge of the first word depends on the divider setting. With divide-by-one, the first word goes out on a rising edge, one full bus period before the rising edge that samples it. With the other ratios, it goes out on a falling edge, half a period ahead. Every later word goes out on a falling edge, so each one has a half-period window before it is sampled. If the stream has no valid word when one is due, the block flags an underrun and stops the burst.

Top module: `dl_burst_launcher`

## Requirements
- R1: The bus clock is low while idle. Its first rising edge follows the second tick after request acceptance. It is then high for div+1 ticks and low for div+1 ticks, where div is the latched 2-bit divider value (0..3).
- R2: With div = 0, word 0 appears on the bus on the first rising edge (tick 2 after acceptance). It is held through the next rising edge (tick 4).
- R3: With div of 1, 2 or 3, word 0 appears on the first falling edge, at tick 2+(div+1) after acceptance.
- R4: Each later word j (j ≥ 1) appears on a falling edge, at tick 2+N+2·N·j with N = div+1. With div = 0 this means word 1 waits for the falling edge after the rising edge that samples word 0.
- R5: With burst enable low, a request carries exactly one word and the length field is ignored. With it high, it carries length+1 words (4-bit length field).
- R6: The stream ready is high for exactly one tick per word, in the tick just before that word's launch edge, and at no other time.
- R7: If the stream is not valid while ready is high, then after that edge the underrun flag is high, and the bus clock, output enable and the "busy" state are cleared. The flag clears on the next accepted request.
- R8: Divider, burst enable and length are sampled only at request acceptance. Changing them during a burst changes neither the timing nor the word count of that burst.
- R9: The data bus holds each word until the next launch. Output enable rises with word 0 and falls one tick after the rising edge that samples the last word. The request ready is high only while idle.
- R10: After reset the bus clock, output enable, stream ready and underrun flag are low, and request ready is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timing clock, twice the functional clock rate |
| rst | input | 1 | Synchronous active-high reset |
| cfg_div_i | input | 2 | Bus clock divider setting (ratio = value+1) |
| cfg_burst_i | input | 1 | Burst enable; low forces single-word transfers |
| req_valid_i | input | 1 | Transfer request |
| req_len_i | input | LEN_W | Words in burst minus one |
| req_ready_o | output | 1 | Block idle, request accepted on this edge |
| wr_data_i | input | DATA_W | Write data stream |
| wr_valid_i | input | 1 | Stream data valid |
| wr_ready_o | output | 1 | Stream data taken on this edge |
| bus_clk_o | output | 1 | Generated bus clock |
| bus_dq_o | output | DATA_W | Data bus drive value |
| bus_oe_o | output | 1 | Data bus output enable (low = high impedance) |
| underrun_o | output | 1 | Stream ran dry during a burst |

## Verification
All timing is counted in edges after the acceptance edge, with N = div+1. The bus clock is due low after edge 1, and after each edge k ≥ 2 it is high when (k−2) mod 2N < N. Word j lands on the edge given in R2 to R4, and stream ready must be high in the tick just before that edge. The bench advances one edge at a time and samples every output on the falling timing-clock edge. At each sample it compares against a value recomputed from these formulas, so every result is checked in the exact tick it is due. For an underrun, the idle state is checked right after the starved edge, and the handshake count is compared at the end of each burst.

// File: rtl/dl_pkg.sv
package dl_pkg;
  // Divider field width; ratio = field + 1
  localparam int DIV_W    = 2;
  localparam int HALF_MAX = 1 << DIV_W;
  // Counters must hold 2*HALF_MAX+1
  localparam int CD_W     = $clog2(2 * HALF_MAX + 2);

  // Timing ticks per bus clock half period
  function automatic logic [CD_W-1:0] half_of(input logic [DIV_W-1:0] d);
    return CD_W'(d) + CD_W'(1);
  endfunction
endpackage

// File: rtl/dl_clkgen.sv
module dl_clkgen
  import dl_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  logic            start_i,
  input  logic            run_i,
  input  logic            end_i,
  input  logic [CD_W-1:0] start_half_i,
  input  logic [CD_W-1:0] half_i,
  output logic            bclk_o
);
  logic [CD_W-1:0] ph_q;
  logic [CD_W-1:0] ph_n;
  logic [CD_W-1:0] per;

  assign per = half_i << 1;

  always_comb begin
    ph_n = (ph_q == per - CD_W'(1)) ? '0 : ph_q + CD_W'(1);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ph_q   <= '0;
      bclk_o <= 1'b0;
    end else if (start_i) begin
      // two low ticks before the first rising edge
      ph_q   <= (start_half_i << 1) - CD_W'(2);
      bclk_o <= 1'b0;
    end else if (run_i && !end_i) begin
      ph_q   <= ph_n;
      bclk_o <= (ph_n < half_i);
    end else begin
      bclk_o <= 1'b0;
    end
  end

  // R1: clock parked low whenever idle
  a_r1_low_when_idle: assert property (@(posedge clk) disable iff (rst)
    !run_i |=> !bclk_o);
endmodule

// File: rtl/dl_sequencer.sv
module dl_sequencer
  import dl_pkg::*;
#(
  parameter int LEN_W  = 4,
  localparam int LEFT_W = LEN_W + 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req_valid_i,
  input  logic [LEN_W-1:0] req_len_i,
  input  logic [DIV_W-1:0] cfg_div_i,
  input  logic             cfg_burst_i,
  input  logic             wr_valid_i,
  output logic             req_ready_o,
  output logic             win_o,
  output logic             take_o,
  output logic             launch_o,
  output logic             first_o,
  output logic             end_o,
  output logic             run_o,
  output logic             start_o,
  output logic [CD_W-1:0]  start_half_o,
  output logic [CD_W-1:0]  half_o,
  output logic             underrun_o
);
  logic              run_q;
  logic [CD_W-1:0]   half_q;
  logic [LEFT_W-1:0] left_q;
  logic              staged_q;
  logic              first_q;
  logic [CD_W-1:0]   cd_q;
  logic              und_q;
  logic              starve;
  logic              fin;
  logic [CD_W-1:0]   reload;

  assign start_o      = !run_q && req_valid_i;
  assign start_half_o = half_of(cfg_div_i);
  assign win_o        = run_q && (left_q != '0) && (cd_q == CD_W'(2));
  assign take_o       = win_o && wr_valid_i;
  assign starve       = win_o && !wr_valid_i;
  assign launch_o     = run_q && staged_q && (cd_q == CD_W'(1));
  assign fin          = run_q && (left_q == '0) && !staged_q && (cd_q == half_q);
  assign end_o        = fin || starve;
  assign req_ready_o  = !run_q;
  assign run_o        = run_q;
  assign half_o       = half_q;
  assign first_o      = first_q;
  assign underrun_o   = und_q;

  // after the first rising-edge launch at ratio 1, skip one falling edge
  assign reload = (first_q && half_q == CD_W'(1)) ? CD_W'(3) : (half_q << 1);

  always_ff @(posedge clk) begin
    if (rst) begin
      run_q    <= 1'b0;
      half_q   <= CD_W'(1);
      left_q   <= '0;
      staged_q <= 1'b0;
      first_q  <= 1'b0;
      cd_q     <= '0;
      und_q    <= 1'b0;
    end else if (start_o) begin
      run_q    <= 1'b1;
      half_q   <= start_half_o;
      left_q   <= cfg_burst_i ? LEFT_W'(req_len_i) + LEFT_W'(1) : LEFT_W'(1);
      staged_q <= 1'b0;
      first_q  <= 1'b1;
      cd_q     <= (cfg_div_i == '0) ? CD_W'(2) : start_half_o + CD_W'(2);
      und_q    <= 1'b0;
    end else if (run_q) begin
      if (end_o) run_q <= 1'b0;
      if (starve) und_q <= 1'b1;
      cd_q <= launch_o ? reload : cd_q - CD_W'(1);
      if (take_o) begin
        left_q   <= left_q - LEFT_W'(1);
        staged_q <= 1'b1;
      end
      if (launch_o) begin
        staged_q <= 1'b0;
        first_q  <= 1'b0;
      end
    end
  end

  // R8: latched ratio never moves during a burst
  a_r8_half_frozen: assert property (@(posedge clk) disable iff (rst)
    (run_q && $past(run_q)) |-> $stable(half_q));
  // R7: a starved window ends the burst with the flag set
  a_r7_starve_stops: assert property (@(posedge clk) disable iff (rst)
    starve |=> (!run_q && und_q));
endmodule

// File: rtl/dl_datapath.sv
module dl_datapath #(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              take_i,
  input  logic              launch_i,
  input  logic              end_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic [DATA_W-1:0] dq_o,
  output logic              oe_o
);
  logic [DATA_W-1:0] stage_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      stage_q <= '0;
      dq_o    <= '0;
      oe_o    <= 1'b0;
    end else begin
      if (take_i)   stage_q <= wr_data_i;
      if (launch_i) dq_o    <= stage_q;
      if (launch_i)   oe_o <= 1'b1;
      else if (end_i) oe_o <= 1'b0;
    end
  end

  // R6: a taken word is launched on the very next edge
  a_r6_take_then_launch: assert property (@(posedge clk) disable iff (rst)
    take_i |=> launch_i);
endmodule

// File: rtl/dl_burst_launcher.sv
module dl_burst_launcher
  import dl_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int LEN_W  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DIV_W-1:0]  cfg_div_i,
  input  logic              cfg_burst_i,
  input  logic              req_valid_i,
  input  logic [LEN_W-1:0]  req_len_i,
  output logic              req_ready_o,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              wr_valid_i,
  output logic              wr_ready_o,
  output logic              bus_clk_o,
  output logic [DATA_W-1:0] bus_dq_o,
  output logic              bus_oe_o,
  output logic              underrun_o
);
  logic            take, launch, first, fin, run, start;
  logic [CD_W-1:0] start_half, half;

  dl_sequencer #(.LEN_W(LEN_W)) i_seq (
    .clk(clk), .rst(rst),
    .req_valid_i(req_valid_i), .req_len_i(req_len_i),
    .cfg_div_i(cfg_div_i), .cfg_burst_i(cfg_burst_i),
    .wr_valid_i(wr_valid_i),
    .req_ready_o(req_ready_o), .win_o(wr_ready_o), .take_o(take),
    .launch_o(launch), .first_o(first), .end_o(fin), .run_o(run),
    .start_o(start), .start_half_o(start_half), .half_o(half),
    .underrun_o(underrun_o)
  );

  dl_clkgen i_clk (
    .clk(clk), .rst(rst), .start_i(start), .run_i(run), .end_i(fin),
    .start_half_i(start_half), .half_i(half), .bclk_o(bus_clk_o)
  );

  dl_datapath #(.DATA_W(DATA_W)) i_dp (
    .clk(clk), .rst(rst), .take_i(take), .launch_i(launch), .end_i(fin),
    .wr_data_i(wr_data_i), .dq_o(bus_dq_o), .oe_o(bus_oe_o)
  );

  // R2: first word at ratio 1 leaves on a rising edge
  a_r2_first_rise: assert property (@(posedge clk) disable iff (rst)
    (launch && first && half == CD_W'(1)) |=> (bus_clk_o && !$past(bus_clk_o)));
  // R3: first word at slower ratios leaves on a falling edge
  a_r3_first_fall: assert property (@(posedge clk) disable iff (rst)
    (launch && first && half != CD_W'(1)) |=> (!bus_clk_o && $past(bus_clk_o)));
  // R4: later words always leave on a falling edge
  a_r4_later_fall: assert property (@(posedge clk) disable iff (rst)
    (launch && !first) |=> (!bus_clk_o && $past(bus_clk_o)));
  // R9: bus driven only inside a burst
  a_r9_oe_in_burst: assert property (@(posedge clk) disable iff (rst)
    bus_oe_o |-> run);
endmodule

// File: tb/test_dl_burst_launcher.sv
module test_dl_burst_launcher;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 16;
  localparam int LW = 4;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [1:0]    cfg_div = '0;
  logic          cfg_burst = 1'b0;
  logic          req_valid = 1'b0;
  logic [LW-1:0] req_len = '0;
  logic          req_ready;
  logic [DW-1:0] wr_data = '0;
  logic          wr_valid = 1'b0;
  logic          wr_ready;
  logic          bus_clk;
  logic [DW-1:0] bus_dq;
  logic          bus_oe;
  logic          underrun;

  int  checks = 0;
  int  failures = 0;
  bit  finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dl_burst_launcher #(.DATA_W(DW), .LEN_W(LW)) i_dl_burst_launcher (
    .clk(clk), .rst(rst), .cfg_div_i(cfg_div), .cfg_burst_i(cfg_burst),
    .req_valid_i(req_valid), .req_len_i(req_len), .req_ready_o(req_ready),
    .wr_data_i(wr_data), .wr_valid_i(wr_valid), .wr_ready_o(wr_ready),
    .bus_clk_o(bus_clk), .bus_dq_o(bus_dq), .bus_oe_o(bus_oe),
    .underrun_o(underrun)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  function automatic int launch_at(input int n, input int j);
    return (n == 1 && j == 0) ? 2 : 2 + n + 2 * n * j;
  endfunction

  function automatic int sample_at(input int n, input int j);
    return (n == 1 && j == 0) ? 4 : launch_at(n, j) + n;
  endfunction

  // one request; und_at < 0 means no underrun; wiggle alters config mid-burst
  task automatic do_burst(input int div, input bit burst, input int len,
                          input int und_at, input bit wiggle);
    int n = div + 1;
    int w = burst ? len + 1 : 1;
    int endk = sample_at(n, w - 1) + 1;
    int lastk = (und_at >= 0) ? launch_at(n, und_at) - 1 : endk;
    int j = 0;
    int nhs = 0;
    logic [DW-1:0] words [16];
    for (int i = 0; i < 16; i++) words[i] = DW'($urandom);
    chk("R9", int'(req_ready), 1);
    cfg_div = 2'(div); cfg_burst = burst; req_len = LW'(len); req_valid = 1'b1;
    @(posedge clk); @(negedge clk);
    req_valid = 1'b0;
    if (wiggle) begin
      cfg_div = 2'(div) ^ 2'd3; cfg_burst = !burst; req_len = ~LW'(len);
    end
    chk("R1", int'(bus_clk), 0);
    chk("R9", int'(bus_oe), 0);
    chk("R7", int'(underrun), 0);
    for (int k = 1; k <= lastk; k++) begin
      bit exp_rdy = (j < w) && (k == launch_at(n, j) - 1);
      int cnt = 0;
      chk("R6", int'(wr_ready), int'(exp_rdy));
      wr_valid = 1'b0;
      if (exp_rdy) begin
        if (j != und_at) begin
          wr_valid = 1'b1; wr_data = words[j]; j++; nhs++;
        end
      end
      @(posedge clk); @(negedge clk);
      wr_valid = 1'b0;
      if (und_at >= 0 && k == lastk) begin
        chk("R7", int'(underrun), 1);
        chk("R7", int'(bus_oe), 0);
        chk("R7", int'(bus_clk), 0);
        chk("R7", int'(req_ready), 1);
        break;
      end
      chk("R1", int'(bus_clk),
          int'(k < endk && k >= 2 && ((k - 2) % (2 * n)) < n));
      for (int q = 0; q < w; q++) if (launch_at(n, q) <= k) cnt = q + 1;
      chk("R9", int'(bus_oe), int'(cnt > 0 && k < endk));
      if (cnt > 0 && k < endk) begin
        if (cnt == 1) chk(n == 1 ? "R2" : "R3", int'(bus_dq), int'(words[0]));
        else          chk("R4", int'(bus_dq), int'(words[cnt - 1]));
      end
    end
    if (und_at < 0) begin
      chk(wiggle ? "R8" : "R5", nhs, w);
      chk("R9", int'(req_ready), 1);
      chk("R7", int'(underrun), 0);
    end
    cfg_div = 2'(div);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R10", int'(bus_clk), 0);
    chk("R10", int'(bus_oe), 0);
    chk("R10", int'(wr_ready), 0);
    chk("R10", int'(underrun), 0);
    chk("R10", int'(req_ready), 1);
    rst = 1'b0;
    @(negedge clk);
    // directed: each ratio, multi-word and single
    for (int d = 0; d < 4; d++) do_burst(d, 1'b1, 3, -1, 1'b0);
    for (int d = 0; d < 4; d++) do_burst(d, 1'b1, 0, -1, 1'b0);
    // burst disabled ignores length (R5)
    do_burst(0, 1'b0, 7, -1, 1'b0);
    do_burst(2, 1'b0, 15, -1, 1'b0);
    // maximum length
    do_burst(1, 1'b1, 15, -1, 1'b0);
    // underrun on first and on later word (R7)
    do_burst(0, 1'b1, 4, 0, 1'b0);
    do_burst(3, 1'b1, 4, 2, 1'b0);
    do_burst(0, 1'b1, 4, 1, 1'b0);
    // config changes mid-burst (R8)
    do_burst(0, 1'b1, 5, -1, 1'b1);
    do_burst(3, 1'b0, 2, -1, 1'b1);
    // random mix
    for (int r = 0; r < 40; r++) begin
      int d = int'($urandom % 4);
      bit b = 1'($urandom % 2);
      int l = int'($urandom % 16);
      int w = b ? l + 1 : 1;
      int u = (($urandom % 5) == 0) ? int'($urandom % w) : -1;
      bit wg = 1'($urandom % 2);
      do_burst(d, b, l, u, wg);
      repeat (int'($urandom % 3)) @(negedge clk);
    end
    finished = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule